// File: doc/BRIEF.md
# Serial Clock/Calendar Access Port

This block is the three-wire serial front end of a real-time clock. An external host enables it with a chip-enable line and picks the transfer direction with a write-select line. It toggles a slow serial clock and moves one bit per rising edge on a data line. The data line is split into a data input, a data output and an output enable, so that a pad cell can be placed outside the block. All four host signals are asynchronous to the system clock. Each one passes through a synchronizer before any edge detection.

A read takes a snapshot of the parallel counter bus on its first serial edge and then shifts the 52-bit frame out, least significant bit first. A write shifts 52 bits in. Only on the final bit does it present the whole word, with a one-cycle load strobe, to the counters. The counters themselves are outside this block. On the first falling serial edge of a write, the block also pulses a sub-second divider reset and raises a carry-inhibit level. That level holds until chip enable drops.

The block keeps two flags of its own. The first is a sticky low-supply flag, set by a periodic voltage sample and cleared by a complete read. The second is a test flag, which is written through the frame and cleared whenever the port is disabled.

Top module: `rtcport_top`

## Requirements
- R1: While chip enable is low, the data output enable is low, serial clock edges cause neither a load strobe nor a divider reset, and the test flag reads 0.
- R2: With chip enable high, write-select low gives read mode (data output enable high) and write-select high gives write mode (data output enable low).
- R3: Frame bit i is carried on serial rising edge i+1. Bits 0-7 are seconds with the low-supply flag at bit 7. Bits 8-15 are minutes, 16-23 hours, 24-27 weekday, 28-35 day, 36-43 month with the test flag at bit 43, and 44-51 year.
- R4: In read mode, the first rising edge captures the counter bus and drives frame bit 0. Each later edge drives the next bit. Counter changes after the first edge do not alter the frame being read.
- R5: After the 52nd rising edge of a read, the data output stays at frame bit 51 however many further edges arrive.
- R6: In write mode, the 52nd rising edge makes the block present the received word with a single load strobe. The first received bit lands at bit 0. Bits after the 52nd are ignored and cause no second strobe.
- R7: A write ended by chip enable falling before 52 bits produces no load strobe.
- R8: In write mode, the first falling serial edge produces exactly one divider-reset pulse and raises carry-inhibit, which stays high until chip enable falls.
- R9: A low-supply sample sets the low-supply flag, and a loaded frame writes it from bit 7. A read reports the flag at bit 7. The flag is cleared by a read that reaches the 52nd edge, and is left set by a shorter read.
- R10: A loaded frame writes the test flag from bit 43. The flag drops to 0 once chip enable is low, so reads report 0 at bit 43.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ceIn | input | 1 | Host chip enable (asynchronous) |
| wrIn | input | 1 | Host direction select, high = write (asynchronous) |
| sclkIn | input | 1 | Host serial clock (asynchronous) |
| dataIn | input | 1 | Serial data from host |
| dataOut | output | 1 | Serial data to host |
| dataOe | output | 1 | Output enable for the data pad |
| cntSnap | input | 52 | Live counter values in frame layout (bits 7 and 43 unused) |
| lowVoltSample | input | 1 | Pulse when the periodic supply check reports low |
| loadStb | output | 1 | One-cycle strobe: loadWord holds a complete written frame |
| loadWord | output | 52 | Received frame for the counters |
| divReset | output | 1 | One-cycle sub-second divider reset |
| carryInhibit | output | 1 | Blocks carries into the seconds counter |
| lowVoltFlag | output | 1 | Sticky low-supply flag |
| testBit | output | 1 | Test flag |

## Verification
The assertions assume that the serial clock, data and direction inputs each stay stable for several system clock cycles around every serial edge. Without that, the synchronizers could see skewed edges. The bench holds each serial phase for six system cycles, which is well above the two-stage synchronizer latency, and it changes data and direction only during the low phase. Mode is changed only while chip enable is low. Random frames and counter snapshots come from a seeded generator, and directed partial, overlong and disabled transfers are mixed in with them.

// File: rtl/rtcport_pkg.sv
package rtcport_pkg;
  localparam int FRAME_BITS = 52;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int FDT_POS    = 7;
  localparam int TM_POS     = 43;

  typedef struct packed {
    logic snap;
    logic shiftOut;
    logic shiftIn;
    logic bitIn;
    logic load;
    logic fdtClr;
    logic tmClr;
  } strobe_t;
endpackage

// File: rtl/rtcport_sync.sv
module rtcport_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rtcport_ctrl.sv
module rtcport_ctrl
  import rtcport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ceIn,
  input  logic    wrIn,
  input  logic    sclkIn,
  input  logic    dataIn,
  output strobe_t stb,
  output logic    rdMode,
  output logic    divReset,
  output logic    carryInhibit
);
  logic [3:0] syncOut;
  logic ceS, wrS, sclkS, dataS, sclkPrev;
  logic sclkRise, sclkFall, wrMode, loadPend;
  logic [CNT_W-1:0] bitCnt;

  rtcport_sync #(.STAGES(SYNC_STAGES), .WIDTH(4)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({ceIn, wrIn, sclkIn, dataIn}),
    .dout (syncOut)
  );
  assign {ceS, wrS, sclkS, dataS} = syncOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclkPrev <= 1'b0;
    else        sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign rdMode   = ceS & ~wrS;
  assign wrMode   = ceS & wrS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                                bitCnt <= '0;
    else if (!ceS)                                             bitCnt <= '0;
    else if (sclkRise && bitCnt < CNT_W'(FRAME_BITS))          bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loadPend     <= 1'b0;
      divReset     <= 1'b0;
      carryInhibit <= 1'b0;
    end else begin
      loadPend <= wrMode & sclkRise & (bitCnt == CNT_W'(FRAME_BITS - 1));
      divReset <= wrMode & sclkFall & (bitCnt == CNT_W'(1)) & ~carryInhibit;
      if (!ceS)
        carryInhibit <= 1'b0;
      else if (wrMode && sclkFall && bitCnt == CNT_W'(1))
        carryInhibit <= 1'b1;
    end
  end

  always_comb begin
    stb.snap     = rdMode & sclkRise & (bitCnt == '0);
    stb.shiftOut = rdMode & sclkRise & (bitCnt != '0) & (bitCnt < CNT_W'(FRAME_BITS));
    stb.shiftIn  = wrMode & sclkRise & (bitCnt < CNT_W'(FRAME_BITS));
    stb.bitIn    = dataS;
    stb.load     = loadPend;
    stb.fdtClr   = rdMode & sclkRise & (bitCnt == CNT_W'(FRAME_BITS - 1));
    stb.tmClr    = ~ceS;
  end

  // R5
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitCnt <= CNT_W'(FRAME_BITS));

  // R8
  inhibit_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ceS |=> !carryInhibit);

  // R8
  divpulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    divReset |=> !divReset);

  // R6
  load_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |-> $past(wrMode));
endmodule

// File: rtl/rtcport_dp.sv
module rtcport_dp
  import rtcport_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               stb,
  input  logic                  rdMode,
  input  logic [FRAME_BITS-1:0] cntSnap,
  input  logic                  lowVoltSample,
  output logic                  dataOut,
  output logic                  dataOe,
  output logic [FRAME_BITS-1:0] loadWord,
  output logic                  lowVoltFlag,
  output logic                  testBit
);
  logic [FRAME_BITS-1:0] shReg, snapWord;
  logic fdtFlag, tmFlag;

  always_comb begin
    snapWord          = cntSnap;
    snapWord[FDT_POS] = fdtFlag;
    snapWord[TM_POS]  = tmFlag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            shReg <= '0;
    else if (stb.snap)     shReg <= snapWord;
    else if (stb.shiftOut) shReg <= {1'b0, shReg[FRAME_BITS-1:1]};
    else if (stb.shiftIn)  shReg <= {stb.bitIn, shReg[FRAME_BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdtFlag <= 1'b0;
      tmFlag  <= 1'b0;
    end else begin
      if (lowVoltSample)   fdtFlag <= 1'b1;
      else if (stb.load)   fdtFlag <= shReg[FDT_POS];
      else if (stb.fdtClr) fdtFlag <= 1'b0;

      if (stb.tmClr)       tmFlag <= 1'b0;
      else if (stb.load)   tmFlag <= shReg[TM_POS];
    end
  end

  assign dataOut     = rdMode ? shReg[0] : 1'b0;
  assign dataOe      = rdMode;
  assign loadWord    = shReg;
  assign lowVoltFlag = fdtFlag;
  assign testBit     = tmFlag;

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.snap | stb.shiftOut | stb.shiftIn) |=> $stable(shReg));

  // R9
  fdt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowVoltSample |=> lowVoltFlag);

  // R10
  tm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.tmClr |=> !testBit);
endmodule

// File: rtl/rtcport_top.sv
module rtcport_top
  import rtcport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ceIn,
  input  logic                  wrIn,
  input  logic                  sclkIn,
  input  logic                  dataIn,
  output logic                  dataOut,
  output logic                  dataOe,
  input  logic [FRAME_BITS-1:0] cntSnap,
  input  logic                  lowVoltSample,
  output logic                  loadStb,
  output logic [FRAME_BITS-1:0] loadWord,
  output logic                  divReset,
  output logic                  carryInhibit,
  output logic                  lowVoltFlag,
  output logic                  testBit
);
  strobe_t stb;
  logic    rdMode;

  rtcport_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .ceIn (ceIn),
    .wrIn (wrIn),
    .sclkIn (sclkIn),
    .dataIn (dataIn),
    .stb (stb),
    .rdMode (rdMode),
    .divReset (divReset),
    .carryInhibit (carryInhibit)
  );

  rtcport_dp u_dp (
    .clk (clk),
    .rst_n (rst_n),
    .stb (stb),
    .rdMode (rdMode),
    .cntSnap (cntSnap),
    .lowVoltSample (lowVoltSample),
    .dataOut (dataOut),
    .dataOe (dataOe),
    .loadWord (loadWord),
    .lowVoltFlag (lowVoltFlag),
    .testBit (testBit)
  );

  assign loadStb = stb.load;
endmodule

// File: tb/tb_rtcport_top.sv
`timescale 1ns/1ps
module tb_rtcport_top;
  localparam int NB   = 52;
  localparam int HALF = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ceIn = 0, wrIn = 0, sclkIn = 0, dataIn = 0, lowVoltSample = 0;
  logic [NB-1:0] cntSnap = '0;
  logic dataOut, dataOe, loadStb, divReset, carryInhibit, lowVoltFlag, testBit;
  logic [NB-1:0] loadWord;

  int checks = 0, fails = 0, loads = 0, divs = 0;
  logic [NB-1:0] lastLoad = '0;
  logic expFdt = 1'b0;
  bit done = 0;

  rtcport_top dut (
    .clk (clk), .rst_n (rst_n), .ceIn (ceIn), .wrIn (wrIn), .sclkIn (sclkIn),
    .dataIn (dataIn), .dataOut (dataOut), .dataOe (dataOe), .cntSnap (cntSnap),
    .lowVoltSample (lowVoltSample), .loadStb (loadStb), .loadWord (loadWord),
    .divReset (divReset), .carryInhibit (carryInhibit),
    .lowVoltFlag (lowVoltFlag), .testBit (testBit)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (loadStb) begin loads <= loads + 1; lastLoad <= loadWord; end
    if (divReset) divs <= divs + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NB-1:0] rnd52();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [NB-1:0] expRead(input logic [NB-1:0] s, input logic f);
    logic [NB-1:0] e = s;
    e[7]  = f;
    e[43] = 1'b0;
    return e;
  endfunction

  task automatic endXfer();
    ceIn = 0; waitc(8); wrIn = 0; waitc(2);
  endtask

  // read n bits (plus extra pulses), returns captured frame and the output seen on extras
  task automatic readBits(input int n, input int extra, input logic [NB-1:0] alt,
                          output logic [NB-1:0] got, output logic extraOk, output logic oe);
    got = '0; extraOk = 1'b1; oe = 1'b0;
    wrIn = 0; ceIn = 1; waitc(HALF);
    for (int i = 0; i < n + extra; i++) begin
      sclkIn = 1; waitc(HALF);
      if (i == 0) cntSnap = alt;
      if (i < n) got[i] = dataOut;
      else if (dataOut !== got[NB-1]) extraOk = 1'b0;
      oe = dataOe;
      sclkIn = 0; waitc(HALF);
    end
  endtask

  task automatic writeBits(input logic [NB-1:0] w, input int n, output logic inhSeen);
    inhSeen = 1'b0;
    wrIn = 1; waitc(2); ceIn = 1; waitc(HALF);
    for (int i = 0; i < n; i++) begin
      dataIn = (i < NB) ? w[i] : ~w[i % NB];
      waitc(HALF);
      if (i == 2) inhSeen = carryInhibit;
      sclkIn = 1; waitc(HALF);
      sclkIn = 0;
    end
    waitc(HALF);
  endtask

  task automatic fullRead(input string tag);
    logic [NB-1:0] snap, got, exp;
    logic ok, oe;
    snap = rnd52();
    cntSnap = snap;
    exp = expRead(snap, expFdt);
    readBits(NB, 4, rnd52(), got, ok, oe);
    chk(got === exp, {tag, " R3 R4 read frame"}, 64'(got), 64'(exp));
    chk(ok, "R5 hold after bit 52", 64'(ok), 64'd1);
    chk(oe, "R2 output enabled in read", 64'(oe), 64'd1);
    endXfer();
    expFdt = 1'b0;
    chk(lowVoltFlag == 1'b0, "R9 flag cleared by full read", 64'(lowVoltFlag), 64'd0);
  endtask

  task automatic fullWrite(input logic [NB-1:0] w, input int n);
    int l0, d0;
    logic inh;
    l0 = loads; d0 = divs;
    writeBits(w, n, inh);
    chk(inh, "R8 carry inhibit during write", 64'(inh), 64'd1);
    chk(dataOe == 1'b0, "R2 output disabled in write", 64'(dataOe), 64'd0);
    chk(loads == l0 + 1, "R6 single load strobe", 64'(loads - l0), 64'd1);
    chk(lastLoad === w, "R6 loaded word", 64'(lastLoad), 64'(w));
    chk(testBit == w[43], "R10 test flag from bit 43", 64'(testBit), 64'(w[43]));
    chk(carryInhibit == 1'b1, "R8 inhibit held while enabled", 64'(carryInhibit), 64'd1);
    endXfer();
    expFdt = w[7];
    chk(divs == d0 + 1, "R8 one divider reset", 64'(divs - d0), 64'd1);
    chk(carryInhibit == 1'b0, "R8 inhibit released", 64'(carryInhibit), 64'd0);
    chk(testBit == 1'b0, "R10 test flag cleared", 64'(testBit), 64'd0);
    chk(lowVoltFlag == expFdt, "R9 flag from bit 7", 64'(lowVoltFlag), 64'(expFdt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] w, got;
    logic ok, oe, inh;
    int l0, d0;
    void'($urandom(32'd20240611));
    waitc(5); rst_n = 1; waitc(5);

    chk(dataOe == 0, "R1 reset oe", 64'(dataOe), 64'd0);
    chk(carryInhibit == 0 && divReset == 0, "R8 reset", 64'(carryInhibit), 64'd0);
    chk(lowVoltFlag == 0 && testBit == 0, "R9 R10 reset flags", 64'({lowVoltFlag, testBit}), 64'd0);

    // R1: clocks with enable low
    l0 = loads; d0 = divs; wrIn = 1; waitc(4);
    for (int i = 0; i < 60; i++) begin
      dataIn = i[0]; sclkIn = 1; waitc(HALF); sclkIn = 0; waitc(HALF);
    end
    chk(loads == l0 && divs == d0, "R1 disabled clocks ignored", 64'(loads - l0 + divs - d0), 64'd0);
    chk(dataOe == 0 && testBit == 0, "R1 disabled outputs", 64'({dataOe, testBit}), 64'd0);
    wrIn = 0; waitc(4);

    // directed: overlong write with bit 7 and 43 set
    w = rnd52(); w[7] = 1; w[43] = 1;
    fullWrite(w, NB + 3);

    // R9: partial read keeps flag, full read reports it and clears
    cntSnap = rnd52();
    readBits(20, 0, cntSnap, got, ok, oe);
    endXfer();
    chk(lowVoltFlag == 1'b1, "R9 partial read keeps flag", 64'(lowVoltFlag), 64'd1);
    fullRead("fdt-set");

    // R7: partial write
    l0 = loads; d0 = divs;
    writeBits(rnd52(), 30, inh);
    endXfer();
    chk(loads == l0, "R7 partial write discarded", 64'(loads - l0), 64'd0);
    chk(divs == d0 + 1, "R8 divider reset on partial write", 64'(divs - d0), 64'd1);

    // R9: voltage sample sets flag
    @(negedge clk) lowVoltSample = 1; @(negedge clk) lowVoltSample = 0;
    waitc(1);
    expFdt = 1'b1;
    chk(lowVoltFlag == 1'b1, "R9 sample sets flag", 64'(lowVoltFlag), 64'd1);
    fullRead("after-sample");

    // random mix
    for (int k = 0; k < 8; k++) begin
      if ($urandom_range(0, 1) == 1) begin
        @(negedge clk) lowVoltSample = 1; @(negedge clk) lowVoltSample = 0;
        expFdt = 1'b1;
      end
      if (k[0]) fullRead("random");
      else      fullWrite(rnd52(), NB + $urandom_range(0, 4));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule